// File: doc/BRIEF.md
# Semi-Digital Hit Counter and Energy Estimator

This block sits behind the readout of one layer of a pixelated calorimeter. Every pad arrives as a 2-bit discriminator code, where higher codes mean the pad's signal crossed higher thresholds. Over one event the block counts how many pads fall in each of three signal bands, and it adds those counts into a hit total. When the event closes, it turns the counts into an energy estimate. The weight of each band is not a constant. It is a quadratic polynomial in the event's total hit count, so the estimate can correct for pads that saturate in dense showers.

Pads arrive as a valid/ready stream. A start flag marks the first pad of an event and an end flag marks the last. Front-end chips deliver 64 pads each, and an event is any number of such groups. After the end flag, one shared multiplier evaluates the three quadratics one after another in Horner form, then scales each weight by its band count. While this runs, the block drops ready so that the next event waits. The nine polynomial coefficients are written through a small address/data port.

Top module: `padEnergyEstimator`

## Requirements
- R1: A pad beat with code 2'b01 adds one to the low-band count, 2'b10 to the mid-band count and 2'b11 to the high-band count, reported on `outCountLow`, `outCountMid` and `outCountHigh`.
- R2: A pad beat with code 2'b00 changes no count and no energy.
- R3: An accepted beat with `inStart` high clears all counts and then counts its own code. A start in the middle of an event discards the pads before it. A single beat with both `inStart` and `inEnd` is a complete one-pad event.
- R4: Beats accepted with no open event leave every count unchanged. An event is open after a start and until its end beat.
- R5: `outTotal` equals the sum of the three band counts.
- R6: With total T, band b's weight is (c2_b*T + c1_b)*T + c0_b. The energy is the sum over bands of weight_b times count_b. Coefficients are signed with 8 fractional bits, so the energy carries 8 fractional bits. `outEnergy` is the low 32 bits of that sum, signed.
- R7: A coefficient write with `cfgAddr` = 3*band + power sets that coefficient. Bands are numbered low=0, mid=1, high=2, and power 0..2 selects c0..c2. Addresses 9 to 15 are ignored. All coefficients reset to zero.
- R8: `outValid` is a single-cycle pulse. It rises exactly 12 clock edges after the edge that accepts the end beat, and `outEnergy` is valid with it.
- R9: `inReady` is low from the edge that accepts an end beat until the cycle in which `outValid` is high. A beat offered in that window is not taken, and it is accepted once ready returns.
- R10: After reset, `inReady` is 1, and `outValid`, `outEnergy` and all counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Pad beat offered |
| inStart | input | 1 | Beat is the first pad of an event |
| inEnd | input | 1 | Beat is the last pad of an event |
| inCode | input | 2 | Pad discriminator code |
| inReady | output | 1 | Beat is accepted on this edge when high |
| cfgWe | input | 1 | Coefficient write strobe |
| cfgAddr | input | 4 | Coefficient index, 3*band + power |
| cfgData | input | 16 | Signed coefficient, 8 fractional bits |
| outValid | output | 1 | One-cycle result strobe |
| outEnergy | output | 32 | Signed energy estimate, 8 fractional bits |
| outCountLow | output | 15 | Low-band pad count |
| outCountMid | output | 15 | Mid-band pad count |
| outCountHigh | output | 15 | High-band pad count |
| outTotal | output | 17 | Total hit count |

## Verification
The first event uses constant weights (c0 only), so a wrong band-to-count mapping or a wrong count is seen directly in the energy. Two patterns with nonzero negative and positive c1 and c2 terms follow. One is a 64-pad group with equal band counts, which isolates the Horner evaluation. The other has unequal counts, which exposes coefficients that are swapped between bands or between powers. Further events are all-empty pads, a one-pad event, a restarted event, stray beats outside any event, and a start held against a busy block. Writes to unused addresses are shown to leave the energy of a repeated event unchanged.

// File: rtl/sdEnergyPkg.sv
package sdEnergyPkg;

  localparam int NUM_BANDS = 3;
  localparam int COEFS_PER_BAND = 3;
  localparam int NUM_COEFS = NUM_BANDS * COEFS_PER_BAND;
  localparam int CALC_CYCLES = NUM_BANDS * 4;

  typedef struct packed {
    logic       clearCounts;
    logic       countEn;
    logic       loadAcc;
    logic       hornerStep;
    logic       accumStep;
    logic       clearEnergy;
    logic       finish;
    logic [1:0] bandSel;
    logic [3:0] coefIdx;
  } ctrlStrobes_t;

endpackage

// File: rtl/sdCoefBank.sv
module sdCoefBank
  import sdEnergyPkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [3:0]               wrAddr,
  input  logic signed [COEF_W-1:0] wrData,
  output logic signed [COEF_W-1:0] coefs [NUM_COEFS]
);

  for (genvar i = 0; i < NUM_COEFS; i++) begin : gCoef
    always_ff @(posedge clk) begin
      if (!rstN) coefs[i] <= '0;
      else if (wrEn && wrAddr == 4'(i)) coefs[i] <= wrData;
    end

    a_r7_write_lands : assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == 4'(i)) |=> (coefs[i] == $past(wrData)));
  end

endmodule

// File: rtl/sdEnergyCtrl.sv
module sdEnergyCtrl
  import sdEnergyPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inStart,
  input  logic         inEnd,
  output logic         inReady,
  output ctrlStrobes_t ctrl
);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_CALC} state_t;

  state_t     state;
  logic [1:0] band;
  logic [1:0] phase;
  logic       beat;

  assign inReady = (state != S_CALC);
  assign beat    = inValid && inReady;

  always_comb begin
    ctrl = '0;
    ctrl.bandSel = band;
    if (state != S_CALC) begin
      ctrl.clearCounts = beat && inStart;
      ctrl.countEn     = beat && (inStart || state == S_COLLECT);
    end else begin
      ctrl.loadAcc     = (phase == 2'd0);
      ctrl.clearEnergy = (phase == 2'd0) && (band == 2'd0);
      ctrl.hornerStep  = (phase == 2'd1) || (phase == 2'd2);
      ctrl.accumStep   = (phase == 2'd3);
      ctrl.finish      = (phase == 2'd3) && (band == 2'(NUM_BANDS - 1));
      case (phase)
        2'd0:    ctrl.coefIdx = 4'(band) * 4'd3 + 4'd2;
        2'd1:    ctrl.coefIdx = 4'(band) * 4'd3 + 4'd1;
        default: ctrl.coefIdx = 4'(band) * 4'd3;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      band  <= '0;
      phase <= '0;
    end else begin
      case (state)
        S_IDLE, S_COLLECT: begin
          band  <= '0;
          phase <= '0;
          if (beat && (inStart || state == S_COLLECT)) begin
            state <= inEnd ? S_CALC : S_COLLECT;
          end
        end
        default: begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            band <= band + 2'd1;
            if (band == 2'(NUM_BANDS - 1)) state <= S_IDLE;
          end
        end
      endcase
    end
  end

  a_r9_busy_after_end : assert property (@(posedge clk) disable iff (!rstN)
    (beat && inEnd && (inStart || state == S_COLLECT)) |=> !inReady);

  a_r9_ready_with_result : assert property (@(posedge clk) disable iff (!rstN)
    ctrl.finish |=> inReady);

endmodule

// File: rtl/sdEnergyDatapath.sv
module sdEnergyDatapath
  import sdEnergyPkg::*;
#(
  parameter int COEF_W = 16,
  parameter int CNT_W  = 15,
  parameter int TOT_W  = 17,
  parameter int ACC_W  = 48,
  parameter int OUT_W  = 32,
  parameter int MAX_PADS = 27648
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             ctrl,
  input  logic [1:0]               code,
  input  logic signed [COEF_W-1:0] coefs [NUM_COEFS],
  output logic [CNT_W-1:0]         countOut [NUM_BANDS],
  output logic [TOT_W-1:0]         total,
  output logic signed [OUT_W-1:0]  energyOut,
  output logic                     resultValid
);

  localparam int PROD_W = ACC_W + TOT_W + 1;

  logic [CNT_W-1:0]        cnt [NUM_BANDS];
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] energy;
  logic signed [ACC_W-1:0] coefExt;
  logic signed [ACC_W-1:0] prodT;
  logic signed [ACC_W-1:0] energyNext;
  logic signed [TOT_W:0]   mulB;
  logic signed [PROD_W-1:0] product;
  logic [CNT_W-1:0]        bandCnt;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : gBand
    logic hitHere;
    assign hitHere = (code == 2'(b + 1));
    always_ff @(posedge clk) begin
      if (!rstN) cnt[b] <= '0;
      else if (ctrl.countEn) begin
        if (ctrl.clearCounts) cnt[b] <= hitHere ? CNT_W'(1) : '0;
        else if (hitHere && cnt[b] < CNT_W'(MAX_PADS)) cnt[b] <= cnt[b] + 1'b1;
      end
    end
    assign countOut[b] = cnt[b];

    a_r3_no_overflow : assert property (@(posedge clk) disable iff (!rstN)
      cnt[b] <= CNT_W'(MAX_PADS));
  end

  always_comb begin
    total = '0;
    for (int b = 0; b < NUM_BANDS; b++) total = total + TOT_W'(cnt[b]);
  end

  always_comb begin
    bandCnt = '0;
    for (int b = 0; b < NUM_BANDS; b++)
      if (ctrl.bandSel == 2'(b)) bandCnt = cnt[b];
  end

  always_comb begin
    coefExt = '0;
    for (int i = 0; i < NUM_COEFS; i++)
      if (ctrl.coefIdx == 4'(i)) coefExt = ACC_W'(coefs[i]);
  end

  // One shared multiplier: weight times total for Horner, weight times band count to accumulate
  assign mulB       = ctrl.accumStep ? $signed({{(TOT_W - CNT_W + 1){1'b0}}, bandCnt})
                                     : $signed({1'b0, total});
  assign product    = PROD_W'(acc) * PROD_W'(mulB);
  assign prodT      = product[ACC_W-1:0];
  assign energyNext = energy + prodT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc         <= '0;
      energy      <= '0;
      energyOut   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= ctrl.finish;
      if (ctrl.loadAcc)         acc <= coefExt;
      else if (ctrl.hornerStep) acc <= prodT + coefExt;
      if (ctrl.clearEnergy)     energy <= '0;
      else if (ctrl.accumStep)  energy <= energyNext;
      if (ctrl.finish)          energyOut <= energyNext[OUT_W-1:0];
    end
  end

  a_r8_single_pulse : assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  a_r2_empty_code_inert : assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.countEn && !ctrl.clearCounts && code == 2'b00) |=> $stable(total));

  a_r5_total_grows : assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.countEn && !ctrl.clearCounts) |=> (total >= $past(total)));

endmodule

// File: rtl/padEnergyEstimator.sv
module padEnergyEstimator
  import sdEnergyPkg::*;
#(
  parameter int PADS_PER_CHIP = 64,
  parameter int NUM_CHIPS     = 432,
  parameter int COEF_W        = 16,
  parameter int ACC_W         = 48,
  parameter int OUT_W         = 32,
  localparam int MAX_PADS     = PADS_PER_CHIP * NUM_CHIPS,
  localparam int CNT_W        = $clog2(MAX_PADS + 1),
  localparam int TOT_W        = CNT_W + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     inStart,
  input  logic                     inEnd,
  input  logic [1:0]               inCode,
  output logic                     inReady,
  input  logic                     cfgWe,
  input  logic [3:0]               cfgAddr,
  input  logic [COEF_W-1:0]        cfgData,
  output logic                     outValid,
  output logic [OUT_W-1:0]         outEnergy,
  output logic [CNT_W-1:0]         outCountLow,
  output logic [CNT_W-1:0]         outCountMid,
  output logic [CNT_W-1:0]         outCountHigh,
  output logic [TOT_W-1:0]         outTotal
);

  ctrlStrobes_t             ctrl;
  logic signed [COEF_W-1:0] coefs [NUM_COEFS];
  logic [CNT_W-1:0]         counts [NUM_BANDS];
  logic signed [OUT_W-1:0]  energy;

  sdCoefBank #(.COEF_W(COEF_W)) uCoef (
    .clk(clk), .rstN(rstN), .wrEn(cfgWe), .wrAddr(cfgAddr),
    .wrData($signed(cfgData)), .coefs(coefs)
  );

  sdEnergyCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart),
    .inEnd(inEnd), .inReady(inReady), .ctrl(ctrl)
  );

  sdEnergyDatapath #(
    .COEF_W(COEF_W), .CNT_W(CNT_W), .TOT_W(TOT_W), .ACC_W(ACC_W),
    .OUT_W(OUT_W), .MAX_PADS(MAX_PADS)
  ) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .code(inCode), .coefs(coefs),
    .countOut(counts), .total(outTotal), .energyOut(energy),
    .resultValid(outValid)
  );

  assign outEnergy    = energy;
  assign outCountLow  = counts[0];
  assign outCountMid  = counts[1];
  assign outCountHigh = counts[2];

  a_r9_ready_at_result : assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady);

endmodule

// File: tb/padEnergyEstimator_test.sv
module padEnergyEstimator_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, inValid, inStart, inEnd, inReady, cfgWe, outValid;
  logic [1:0]  inCode;
  logic [3:0]  cfgAddr;
  logic [15:0] cfgData;
  logic [31:0] outEnergy;
  logic [14:0] outCountLow, outCountMid, outCountHigh;
  logic [16:0] outTotal;

  padEnergyEstimator uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart), .inEnd(inEnd),
    .inCode(inCode), .inReady(inReady), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .outValid(outValid), .outEnergy(outEnergy),
    .outCountLow(outCountLow), .outCountMid(outCountMid),
    .outCountHigh(outCountHigh), .outTotal(outTotal)
  );

  int nRun = 0;
  int nFail = 0;
  longint cf [9];
  logic [1:0] padBuf [256];
  int padLen;

  task automatic checkEq(string req, string what, longint act, longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeCoef(int idx, longint val);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'(idx); cfgData = 16'(val);
    @(negedge clk);
    cfgWe = 1'b0;
    if (idx < 9) cf[idx] = longint'($signed(16'(val)));
  endtask

  task automatic beat(bit s, bit e, logic [1:0] c);
    @(negedge clk);
    inValid = 1'b1; inStart = s; inEnd = e; inCode = c;
    while (!inReady) @(negedge clk);
  endtask

  task automatic sendBuffered();
    for (int i = 0; i < padLen; i++) beat(i == 0, i == padLen - 1, padBuf[i]);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
  endtask

  task automatic waitResult(output int edges);
    edges = 0;
    while (!outValid && edges < 100) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
  endtask

  function automatic longint model(longint n1, longint n2, longint n3);
    longint t, e, w;
    longint n [3];
    n[0] = n1; n[1] = n2; n[2] = n3;
    t = n1 + n2 + n3;
    e = 0;
    for (int b = 0; b < 3; b++) begin
      w = (cf[3*b+2] * t + cf[3*b+1]) * t + cf[3*b];
      e += w * n[b];
    end
    return longint'($signed(32'(e)));
  endfunction

  task automatic runBuffered(string req);
    longint n [4];
    int edges;
    for (int k = 0; k < 4; k++) n[k] = 0;
    for (int i = 0; i < padLen; i++) n[padBuf[i]]++;
    sendBuffered();
    waitResult(edges);
    checkEq("R8", {req, " latency"}, edges, 12);
    checkEq("R1", {req, " low count"}, outCountLow, n[1]);
    checkEq("R1", {req, " mid count"}, outCountMid, n[2]);
    checkEq("R1", {req, " high count"}, outCountHigh, n[3]);
    checkEq("R5", {req, " total"}, outTotal, n[1] + n[2] + n[3]);
    checkEq("R6", {req, " energy"}, longint'($signed(outEnergy)), model(n[1], n[2], n[3]));
    @(negedge clk);
    checkEq("R8", {req, " pulse width"}, outValid, 0);
  endtask

  task automatic testReset();
    checkEq("R10", "ready", inReady, 1);
    checkEq("R10", "valid", outValid, 0);
    checkEq("R10", "energy", outEnergy, 0);
    checkEq("R10", "total", outTotal, 0);
  endtask

  task automatic testZeroCoefs();
    padLen = 4; padBuf[0] = 2'b01; padBuf[1] = 2'b10; padBuf[2] = 2'b11; padBuf[3] = 2'b11;
    runBuffered("R7 reset coefficients");
    checkEq("R7", "energy with reset coefficients", outEnergy, 0);
  endtask

  task automatic testConstWeights();
    writeCoef(0, 256); writeCoef(3, 512); writeCoef(6, 768);
    padLen = 14;
    for (int i = 0; i < 14; i++)
      padBuf[i] = (i < 5) ? 2'b01 : (i < 8) ? 2'b10 : (i < 10) ? 2'b11 : 2'b00;
    runBuffered("R1 constant weights");
    checkEq("R6", "constant weight energy", outEnergy, 4352);
  endtask

  task automatic testIgnoredAddr();
    for (int a = 9; a < 16; a++) writeCoef(a, 16'h7fff);
    runBuffered("R7 unused addresses");
    checkEq("R7", "energy after unused writes", outEnergy, 4352);
  endtask

  task automatic testQuadratic();
    writeCoef(2, -2);  writeCoef(1, 40);   writeCoef(0, 300);
    writeCoef(5, 3);   writeCoef(4, -100); writeCoef(3, 1000);
    writeCoef(8, 1);   writeCoef(7, 5);    writeCoef(6, -50);
    padLen = 64;
    for (int i = 0; i < 64; i++) padBuf[i] = 2'(i % 4);
    runBuffered("R6 equal bands");
    for (int i = 0; i < 64; i++)
      padBuf[i] = (i < 30) ? 2'b01 : (i < 40) ? 2'b10 : (i < 45) ? 2'b11 : 2'b00;
    runBuffered("R6 unequal bands");
  endtask

  task automatic testAllEmpty();
    padLen = 64;
    for (int i = 0; i < 64; i++) padBuf[i] = 2'b00;
    runBuffered("R2 empty pads");
    checkEq("R2", "energy of empty event", outEnergy, 0);
  endtask

  task automatic testSinglePad();
    padLen = 1; padBuf[0] = 2'b10;
    runBuffered("R3 one-pad event");
  endtask

  task automatic testRestart();
    int edges;
    beat(1, 0, 2'b11); beat(0, 0, 2'b11); beat(0, 0, 2'b01);
    beat(1, 0, 2'b10); beat(0, 1, 2'b01);
    @(posedge clk); @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
    waitResult(edges);
    checkEq("R3", "restart high count", outCountHigh, 0);
    checkEq("R3", "restart low count", outCountLow, 1);
    checkEq("R3", "restart mid count", outCountMid, 1);
    checkEq("R3", "restart energy", longint'($signed(outEnergy)), model(1, 1, 0));
  endtask

  task automatic testStray();
    logic [14:0] hi0, lo0;
    @(negedge clk);
    hi0 = outCountHigh; lo0 = outCountLow;
    beat(0, 0, 2'b11); beat(0, 0, 2'b01); beat(0, 1, 2'b11);
    @(posedge clk); @(negedge clk);
    inValid = 1'b0; inEnd = 1'b0;
    checkEq("R4", "stray beats high count", outCountHigh, hi0);
    checkEq("R4", "stray beats low count", outCountLow, lo0);
    repeat (3) @(negedge clk);
    checkEq("R4", "no result from stray end", outValid, 0);
    checkEq("R4", "still ready", inReady, 1);
    padLen = 3; padBuf[0] = 2'b11; padBuf[1] = 2'b01; padBuf[2] = 2'b11;
    runBuffered("R4 event after stray beats");
  endtask

  task automatic testHoldOff();
    int edges;
    bit readyLeak;
    readyLeak = 0;
    padLen = 5;
    for (int i = 0; i < 5; i++) padBuf[i] = 2'(i % 3 + 1);
    for (int i = 0; i < padLen; i++) beat(i == 0, i == padLen - 1, padBuf[i]);
    @(posedge clk); @(negedge clk);
    inValid = 1'b1; inStart = 1'b1; inEnd = 1'b1; inCode = 2'b11;
    edges = 0;
    while (!outValid && edges < 100) begin
      if (inReady) readyLeak = 1;
      @(posedge clk); edges++; @(negedge clk);
    end
    checkEq("R9", "ready low while busy", readyLeak, 0);
    checkEq("R9", "ready high at result", inReady, 1);
    checkEq("R9", "first event energy", longint'($signed(outEnergy)), model(2, 2, 1));
    @(posedge clk); @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
    waitResult(edges);
    checkEq("R9", "held beat latency", edges, 12);
    checkEq("R9", "held beat high count", outCountHigh, 1);
    checkEq("R9", "held beat energy", longint'($signed(outEnergy)), model(0, 0, 1));
  endtask

  initial begin
    for (int i = 0; i < 9; i++) cf[i] = 0;
    rstN = 1'b0; inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0; inCode = 2'b00;
    cfgWe = 1'b0; cfgAddr = 4'd0; cfgData = 16'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroCoefs();
    testConstWeights();
    testIgnoredAddr();
    testQuadratic();
    testAllEmpty();
    testSinglePad();
    testRestart();
    testStray();
    testHoldOff();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog run did not complete");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule